// File: doc/BRIEF.md
# Multiply-Accumulate Batch Sequencer

This block is the control engine that walks a multiply-accumulate datapath through one batch of operand pairs. After a start request it clears the datapath once. It then repeats a fixed pattern for each pair: capture the operands, launch a sequential multiplier, wait as long as the multiplier needs, and fold the product into the accumulator. When the last pair has been added it goes back to waiting for the next request.

Every command leaves the block as a single-cycle strobe from a flip-flop. At most one command is high in any cycle, so the datapath can use the commands directly as enables. The multiplier tells the block that it has finished by raising a done flag, and the wait for that flag may last any number of cycles. The number of pairs in a batch is a parameter, with a default of ten. A pair-done pulse goes out together with each accumulate command, so the operand source can present the next pair. All pins are plain control pins. No data passes through this block, so it has no valid/ready stream and no back-pressure.

Top module: `mac_sequencer`

## Requirements
- R1: While `rst_n` is low, and at any moment it falls, all five outputs are low at once (asynchronous reset). After reset the block is idle and issues no command, whatever the level of `mul_done`.
- R2: While idle, the block waits until `start_req` is sampled high on a rising clock edge. A `start_req` pulse that arrives while a batch is in progress has no effect: no extra clear is issued and the batch keeps its length.
- R3: In the cycle after `start_req` is sampled, `dp_clear` is high for exactly one cycle. `opnd_load` follows in the next cycle.
- R4: `opnd_load` is high for exactly one cycle, and `mul_begin` is high in the cycle after it, also for one cycle.
- R5: After `mul_begin`, the block issues no command until it samples `mul_done` high. It samples `mul_done` from the cycle after `mul_begin` onward. With the done flag first high L cycles after that cycle, `acc_add` appears L+2 cycles after `mul_begin`.
- R6: `acc_add` and `pair_done` are high together for exactly one cycle, in the cycle after `mul_done` is sampled.
- R7: A batch holds exactly PAIRS (default 10) accumulate commands. After each one except the last, `opnd_load` follows in the next cycle. After the last one the block returns to idle and issues nothing more.
- R8: A new `start_req` after a batch has completed runs a complete new batch of PAIRS pairs, because the pair count is reloaded during the clear step.
- R9: At most one of `dp_clear`, `opnd_load`, `mul_begin`, `acc_add` is high in any cycle.
- R10: Pulling `rst_n` low in the middle of a batch abandons the batch. The block then waits idle for a new start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req | input | 1 | Request to run one batch |
| mul_done | input | 1 | Multiplier has finished the current product |
| dp_clear | output | 1 | One-cycle datapath clear |
| opnd_load | output | 1 | One-cycle operand register load |
| mul_begin | output | 1 | One-cycle multiplier launch |
| acc_add | output | 1 | One-cycle accumulate command |
| pair_done | output | 1 | One-cycle request for the next operand pair |

## Verification
The bound assertions check the local command ordering on every cycle. They cover the mutual exclusion of commands, clear followed by load, load followed by launch, silence right after a launch, and `pair_done` pulsing together with `acc_add`. A counter in the checker also limits the number of accumulates between two clears. Only the bench scenarios can show the complete picture. They cover the exact batch length and the return to idle, how long the block waits for multiplier latencies that change from pair to pair, whether start pulses during a run are ignored, the reload of the pair count on a second batch, and recovery from a reset in the middle of a batch. The bench checks these with a scoreboard that compares each command and its cycle gap from the previous command against an expected list.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_LOAD  = 3'd2,
    ST_LAUNCH = 3'd3,
    ST_WAIT  = 3'd4,
    ST_ACCUM = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic clear;
    logic load;
    logic launch;
    logic accum;
  } seq_cmd_t;
endpackage

// File: rtl/mac_pair_counter.sv
module mac_pair_counter #(
  parameter int PAIRS = 10,
  localparam int CW = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic step,
  output logic last
);
  localparam logic [CW-1:0] PRESET = CW'(PAIRS - 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         remain <= PRESET;
    else if (reload)                    remain <= PRESET;
    else if (step && remain != '0)      remain <= remain - 1'b1;
  end

  assign last = (remain == '0);
endmodule

// File: rtl/mac_seq_fsm.sv
module mac_seq_fsm
  import mac_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       mul_done,
  input  logic       last,
  output seq_state_t state,
  output seq_state_t state_nxt
);
  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:   if (start_req) state_nxt = ST_CLEAR;
      ST_CLEAR:  state_nxt = ST_LOAD;
      ST_LOAD:   state_nxt = ST_LAUNCH;
      ST_LAUNCH: state_nxt = ST_WAIT;
      ST_WAIT:   if (mul_done) state_nxt = ST_ACCUM;
      ST_ACCUM:  state_nxt = last ? ST_IDLE : ST_LOAD;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/mac_cmd_reg.sv
module mac_cmd_reg
  import mac_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_t state_nxt,
  output seq_cmd_t   cmd,
  output logic       finish
);
  seq_cmd_t cmd_d;

  always_comb begin
    cmd_d        = '0;
    cmd_d.clear  = (state_nxt == ST_CLEAR);
    cmd_d.load   = (state_nxt == ST_LOAD);
    cmd_d.launch = (state_nxt == ST_LAUNCH);
    cmd_d.accum  = (state_nxt == ST_ACCUM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd    <= '0;
      finish <= 1'b0;
    end else begin
      cmd    <= cmd_d;
      finish <= cmd_d.accum;
    end
  end
endmodule

// File: rtl/mac_sequencer.sv
module mac_sequencer
  import mac_seq_pkg::*;
#(
  parameter int PAIRS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic mul_done,
  output logic dp_clear,
  output logic opnd_load,
  output logic mul_begin,
  output logic acc_add,
  output logic pair_done
);
  seq_state_t state, state_nxt;
  seq_cmd_t   cmd;
  logic       last;

  mac_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .mul_done  (mul_done),
    .last      (last),
    .state     (state),
    .state_nxt (state_nxt)
  );

  mac_pair_counter #(.PAIRS(PAIRS)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (state == ST_CLEAR),
    .step   (state == ST_ACCUM),
    .last   (last)
  );

  mac_cmd_reg u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_nxt (state_nxt),
    .cmd       (cmd),
    .finish    (pair_done)
  );

  assign dp_clear  = cmd.clear;
  assign opnd_load = cmd.load;
  assign mul_begin = cmd.launch;
  assign acc_add   = cmd.accum;
endmodule

// File: rtl/mac_seq_checker.sv
module mac_seq_checker #(
  parameter int PAIRS = 10,
  localparam int KW = $clog2(PAIRS + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic mul_done,
  input logic dp_clear,
  input logic opnd_load,
  input logic mul_begin,
  input logic acc_add,
  input logic pair_done
);
  logic [KW-1:0] adds_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        adds_seen <= '0;
    else if (dp_clear) adds_seen <= '0;
    else if (acc_add)  adds_seen <= adds_seen + 1'b1;
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dp_clear, opnd_load, mul_begin, acc_add})); // R9

  AST_CLEAR_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dp_clear |=> (opnd_load && !dp_clear)); // R3

  AST_LOAD_THEN_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_load |=> (mul_begin && !opnd_load)); // R4

  AST_LAUNCH_THEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mul_begin |=> !(dp_clear || opnd_load || mul_begin || acc_add)); // R5

  AST_ADD_WITH_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    acc_add |-> pair_done); // R6

  AST_FINISH_WITH_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done |-> acc_add); // R6

  AST_ADD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_add |=> !acc_add); // R6

  AST_BATCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    acc_add |-> (adds_seen < KW'(PAIRS))); // R7

  AST_ADD_THEN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_add && adds_seen < KW'(PAIRS - 1)) |=> opnd_load); // R7

  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_done && mul_begin) |=> !acc_add); // R5
endmodule

bind mac_sequencer mac_seq_checker #(.PAIRS(PAIRS)) u_chk (.*);

// File: tb/sim_mac_sequencer.sv
module sim_mac_sequencer;
  localparam int PAIRS = 10;
  localparam int K_CLR = 1, K_LOAD = 2, K_BEGIN = 3, K_ADD = 4, K_BAD = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic mul_done = 1'b0;
  logic dp_clear, opnd_load, mul_begin, acc_add, pair_done;

  int n_checks = 0;
  int n_fails = 0;
  int cyc = 0;
  int last_evt = 0;
  int pair_idx = 0;
  int lat_tab [PAIRS];
  int exp_q [$];
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  mac_sequencer #(.PAIRS(PAIRS)) u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .mul_done(mul_done),
    .dp_clear(dp_clear), .opnd_load(opnd_load), .mul_begin(mul_begin),
    .acc_add(acc_add), .pair_done(pair_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  // Monitor: scoreboard comparison at the falling edge
  always @(negedge clk) begin
    int kind, item;
    cyc++;
    kind = 0;
    if ((int'(dp_clear) + int'(opnd_load) + int'(mul_begin) + int'(acc_add)) > 1) kind = K_BAD;
    else if (dp_clear)  kind = K_CLR;
    else if (opnd_load) kind = K_LOAD;
    else if (mul_begin) kind = K_BEGIN;
    else if (acc_add)   kind = pair_done ? K_ADD : K_BAD;
    else if (pair_done) kind = K_BAD;
    if (kind != 0 && rst_n) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R7 unexpected command", kind, 0);
      end else begin
        item = exp_q.pop_front();
        check(kind == (item & 15), "R3-R9 command kind", kind, item & 15);
        if ((item >> 4) != 0)
          check((cyc - last_evt) == (item >> 4), "R5/R7 cycle gap", cyc - last_evt, item >> 4);
      end
      last_evt = cyc;
    end
  end

  // Multiplier response model
  initial begin
    forever begin
      @(negedge clk);
      if (mul_begin && rst_n) begin
        int lat;
        lat = lat_tab[pair_idx % PAIRS];
        pair_idx++;
        @(posedge clk);
        repeat (lat) @(posedge clk);
        #1 mul_done = 1'b1;
        @(posedge clk);
        #1 mul_done = 1'b0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  task automatic push_batch(input int n);
    exp_q.push_back(K_CLR);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(K_LOAD | (1 << 4));
      exp_q.push_back(K_BEGIN | (1 << 4));
      exp_q.push_back(K_ADD | ((lat_tab[i] + 2) << 4));
    end
  endtask

  task automatic pulse_start();
    @(posedge clk);
    #1 start_req = 1'b1;
    @(posedge clk);
    #1 start_req = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    int guard;
    guard = 0;
    while (exp_q.size() != 0 && guard < 3000) begin
      @(posedge clk);
      guard++;
    end
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    repeat (6) @(posedge clk);
  endtask

  initial begin
    // R1: reset state, mul_done noise ignored
    mul_done = 1'b1;
    #1;
    check({dp_clear, opnd_load, mul_begin, acc_add, pair_done} == 5'b0, "R1 outputs in reset",
          {dp_clear, opnd_load, mul_begin, acc_add, pair_done}, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 mul_done = 1'b0;
    @(negedge clk);
    check({dp_clear, opnd_load, mul_begin, acc_add, pair_done} == 5'b0, "R1 idle after reset",
          {dp_clear, opnd_load, mul_begin, acc_add, pair_done}, 0);
    repeat (5) @(posedge clk);

    // Batch 1: varying latency, stray start pulses ignored (R2, R5, R7)
    for (int i = 0; i < PAIRS; i++) lat_tab[i] = (i * 3) % 5;
    pair_idx = 0;
    push_batch(PAIRS);
    pulse_start();
    repeat (15) @(posedge clk);
    pulse_start();  // R2 ignored mid-batch
    repeat (10) @(posedge clk);
    pulse_start();  // R2 ignored mid-batch
    wait_drain("R7 batch one complete");
    check(exp_q.size() == 0, "R7 idle after last add", exp_q.size(), 0);

    // Batch 2: zero latency, fresh count of PAIRS (R8)
    for (int i = 0; i < PAIRS; i++) lat_tab[i] = 0;
    pair_idx = 0;
    push_batch(PAIRS);
    pulse_start();
    wait_drain("R8 second batch complete");

    // Batch 3: long latency (R5)
    for (int i = 0; i < PAIRS; i++) lat_tab[i] = 7;
    pair_idx = 0;
    push_batch(PAIRS);
    pulse_start();
    wait_drain("R5 long-latency batch complete");

    // R10: reset in the middle of a batch
    for (int i = 0; i < PAIRS; i++) lat_tab[i] = 50;
    pair_idx = 0;
    exp_q.push_back(K_CLR);
    exp_q.push_back(K_LOAD | (1 << 4));
    exp_q.push_back(K_BEGIN | (1 << 4));
    pulse_start();
    repeat (8) @(posedge clk);
    check(exp_q.size() == 0, "R10 partial batch seen", exp_q.size(), 0);
    #2 rst_n = 1'b0;
    #0.5;
    check({dp_clear, opnd_load, mul_begin, acc_add, pair_done} == 5'b0, "R1 async reset clears outputs",
          {dp_clear, opnd_load, mul_begin, acc_add, pair_done}, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (70) @(posedge clk);  // stale mul_done arrives while idle
    check(exp_q.size() == 0, "R10 idle after reset", exp_q.size(), 0);

    // R10: a full batch runs after recovery
    for (int i = 0; i < PAIRS; i++) lat_tab[i] = i % 3;
    pair_idx = 0;
    push_batch(PAIRS);
    pulse_start();
    wait_drain("R10 batch after recovery");

    finish_run();
  end
endmodule